// File: doc/BRIEF.md
# Lockable Retained Seconds Clock Controller

This block is a time-of-day counter (seconds, minutes, hours) whose settings exist in two copies. The first is a host-visible control register in the ordinary system domain. The second is an effective configuration held in a battery-backed retained domain, and this copy is the one that actually steers the counter. A retained lock bit selects between two cases. While the lock is clear, the effective copy tracks the visible register. While the lock is set, the effective copy is frozen. Neither host writes nor system resets can then disturb the running clock, even though the visible register may read differently.

The block has two resets. The system reset restores the visible register, which returns with its hold bit set. The backup power-on reset clears the retained lock, the effective configuration and the counters. Host software reads the lock after start-up. A clear lock marks a first power-up: the host then configures the block, clears hold and sets the lock. To change settings later, the host sets hold, clears the lock, edits the fields, clears hold and sets the lock again.

A one-cycle tick input marks each second. A prescale field in the control register can stretch this, so that one second is counted for every (prescale+1) unheld ticks.

Top module: `rtc_lockctl`

## Requirements
- R1: The control register (address 0) has hold at bit 0 and a 2-bit prescale at bits 2:1. A system reset sets it to hold=1, prescale=0.
- R2: The visible hold bit is never cleared by hardware. It keeps reading 1 until a host write to address 0 clears it.
- R3: While the lock is 0, the effective configuration follows the control register one cycle after a write. An effective hold of 1 freezes the counters, and an effective hold of 0 lets ticks advance them.
- R4: The lock register (address 1, bit 0) is retained. A system reset leaves it unchanged. A host write of 0 or a backup power-on reset clears it, and after a backup power-on reset it reads 0.
- R5: While the lock is 1, host writes to the control register and system resets change its readback but not the counting behaviour.
- R6: A 0-to-1 lock write captures the visible control contents, including hold, in the cycle of the write. A hold of 1 captured this way keeps the counters stopped while locked.
- R7: After the host clears the lock with hold set, the counters stop. Settings edited and then re-locked with hold cleared take effect.
- R8: Seconds and minutes count 0..59 and carry on wrap. Hours count 0..23 and wrap to 0.
- R9: With prescale p, the seconds advance once per p+1 unheld tick cycles.
- R10: The counters are readable on the outputs at all times, and a backup power-on reset sets them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Active-low system reset, applies to the visible register |
| bkp_por_n | input | 1 | Active-low backup-domain power-on reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 lock |
| wr_data | input | 3 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 lock |
| rd_data | output | 3 | Combinational readback |
| tick | input | 1 | One-cycle second pulse |
| sec | output | 6 | Seconds count |
| min | output | 6 | Minutes count |
| hr | output | 5 | Hours count |

## Verification
A wrong effective configuration is never visible on rd_data. It shows up only as a seconds count that runs when it should be frozen, or stops when it should run. The bench therefore checks the count after every tick burst, and a mismatch appears at most one tick after the fault. A wrong carry or wrap shows up as a wrong seconds, minutes or hours value on the cycle after the tick that crosses the boundary. The bench sweeps a full day tick by tick and compares every cycle against the arithmetic expectation. A lost or self-clearing lock or hold bit shows up on the very next readback, and the bench reads both registers after each reset.

// File: rtl/rtc_lock_pkg.sv
package rtc_lock_pkg;
    localparam int PRE_W  = 2;
    localparam int CTRL_W = PRE_W + 1;
    localparam int SEC_W  = 6;
    localparam int HR_W   = 5;
    localparam int SEC_TOP = 59;
    localparam int MIN_TOP = 59;
    localparam int HR_TOP  = 23;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             hold;
    } ctrl_t;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [SEC_W-1:0] min;
        logic [SEC_W-1:0] sec;
        logic [PRE_W-1:0] div;
    } time_t;

    localparam ctrl_t CTRL_RST = '{pre: '0, hold: 1'b1};
endpackage

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtc_lock_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             vis_o
);
    ctrl_t vis_d, vis_q;

    always_comb begin
        vis_d = vis_q;
        if (wr_en && !wr_addr)
            vis_d = ctrl_t'(wr_data);
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) vis_q <= CTRL_RST;
        else            vis_q <= vis_d;
    end

    assign vis_o = vis_q;

    AST_HOLD_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (vis_q.hold && !(wr_en && !wr_addr)) |=> vis_q.hold); // R2
endmodule

// File: rtl/rtc_retained.sv
module rtc_retained
    import rtc_lock_pkg::*;
(
    input  logic              clk,
    input  logic              bkp_por_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  ctrl_t             vis_i,
    output ctrl_t             eff_o,
    output logic              lock_o
);
    typedef struct packed {
        logic  lock;
        ctrl_t eff;
    } ret_t;

    ret_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // unlocked: track visible copy; this also captures it on a 0->1 lock write
        if (!r_q.lock)
            r_d.eff = vis_i;
        if (wr_en && wr_addr)
            r_d.lock = wr_data[0];
    end

    always_ff @(posedge clk or negedge bkp_por_n) begin
        if (!bkp_por_n) r_q <= '{lock: 1'b0, eff: CTRL_RST};
        else            r_q <= r_d;
    end

    assign eff_o  = r_q.eff;
    assign lock_o = r_q.lock;

    AST_LOCK_RETAINED: assert property (@(posedge clk) disable iff (!bkp_por_n)
        (r_q.lock && !(wr_en && wr_addr && !wr_data[0])) |=> r_q.lock); // R4
    AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (!bkp_por_n)
        r_q.lock |=> $stable(r_q.eff)); // R5
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
    import rtc_lock_pkg::*;
(
    input  logic             clk,
    input  logic             bkp_por_n,
    input  logic             tick,
    input  ctrl_t            eff_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [SEC_W-1:0] min_o,
    output logic [HR_W-1:0]  hr_o
);
    time_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (tick && !eff_i.hold) begin
            if (t_q.div >= eff_i.pre) begin
                t_d.div = '0;
                if (t_q.sec == SEC_W'(SEC_TOP)) begin
                    t_d.sec = '0;
                    if (t_q.min == SEC_W'(MIN_TOP)) begin
                        t_d.min = '0;
                        t_d.hr  = (t_q.hr == HR_W'(HR_TOP)) ? '0 : t_q.hr + 1'b1;
                    end else begin
                        t_d.min = t_q.min + 1'b1;
                    end
                end else begin
                    t_d.sec = t_q.sec + 1'b1;
                end
            end else begin
                t_d.div = t_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge bkp_por_n) begin
        if (!bkp_por_n) t_q <= '0;
        else            t_q <= t_d;
    end

    assign sec_o = t_q.sec;
    assign min_o = t_q.min;
    assign hr_o  = t_q.hr;

    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!bkp_por_n)
        eff_i.hold |=> $stable({t_q.hr, t_q.min, t_q.sec})); // R3
    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!bkp_por_n)
        (t_q.sec <= SEC_W'(SEC_TOP)) && (t_q.min <= SEC_W'(MIN_TOP))); // R8
    AST_HR_RANGE: assert property (@(posedge clk) disable iff (!bkp_por_n)
        t_q.hr <= HR_W'(HR_TOP)); // R8
endmodule

// File: rtl/rtc_lockctl.sv
module rtc_lockctl
    import rtc_lock_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              bkp_por_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              tick,
    output logic [SEC_W-1:0]  sec,
    output logic [SEC_W-1:0]  min,
    output logic [HR_W-1:0]   hr
);
    ctrl_t vis, eff;
    logic  lock;

    rtc_host_regs u_regs (
        .clk(clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vis_o(vis)
    );

    rtc_retained u_ret (
        .clk(clk), .bkp_por_n(bkp_por_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vis_i(vis), .eff_o(eff), .lock_o(lock)
    );

    rtc_time_cnt u_cnt (
        .clk(clk), .bkp_por_n(bkp_por_n), .tick(tick), .eff_i(eff),
        .sec_o(sec), .min_o(min), .hr_o(hr)
    );

    always_comb begin
        rd_data = rd_addr ? {{(CTRL_W-1){1'b0}}, lock} : CTRL_W'(vis);
    end
endmodule

// File: tb/sim_rtc_lockctl.sv
module sim_rtc_lockctl;
    logic clk = 1'b0;
    logic sys_rst_n = 1'b0, bkp_por_n = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0, tick = 1'b0;
    logic [2:0] wr_data = '0;
    logic [2:0] rd_data;
    logic [5:0] sec, min;
    logic [4:0] hr;

    int n_cmp = 0, n_bad = 0;
    int exp_t = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_lockctl u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .bkp_por_n(bkp_por_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .sec(sec), .min(min), .hr(hr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_time(input string req);
        int e;
        e = exp_t % 86400;
        chk(req, {27'd0, hr} * 3600 + {26'd0, min} * 60 + {26'd0, sec}, e);
    endtask

    task automatic rd(input logic a, output int v);
        rd_addr = a; #1; v = {29'd0, rd_data};
    endtask

    task automatic wr(input logic a, input logic [2:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic sys_reset();
        @(negedge clk); sys_rst_n = 1'b0;
        repeat (2) @(negedge clk); sys_rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        sys_rst_n = 1'b1; bkp_por_n = 1'b1;
        @(negedge clk);
        rd(1'b0, v); chk("R1 ctrl reset", v, 1);
        rd(1'b1, v); chk("R4 lock after por", v, 0);
        chk_time("R10 time after por");

        ticks(5);
        chk_time("R3 held no count");
        rd(1'b0, v); chk("R2 hold still set", v, 1);

        wr(1'b0, 3'b000);
        ticks(10); exp_t += 10;
        chk_time("R3 unheld count");

        wr(1'b0, 3'b100);
        ticks(9); exp_t += 3;
        chk_time("R9 prescale 2");
        wr(1'b0, 3'b000);

        wr(1'b1, 3'b001);
        rd(1'b1, v); chk("R4 lock set", v, 1);
        ticks(7); exp_t += 7;
        chk_time("R5 locked runs");
        wr(1'b0, 3'b001);
        rd(1'b0, v); chk("R5 readback shows hold", v, 1);
        ticks(5); exp_t += 5;
        chk_time("R5 write ignored");
        sys_reset();
        rd(1'b1, v); chk("R4 lock survives sys reset", v, 1);
        rd(1'b0, v); chk("R1 ctrl after sys reset", v, 1);
        ticks(5); exp_t += 5;
        chk_time("R5 sys reset ignored");

        wr(1'b1, 3'b000);
        ticks(4);
        chk_time("R7 unlock with hold stops");
        wr(1'b0, 3'b011);
        wr(1'b0, 3'b010);
        wr(1'b1, 3'b001);
        ticks(6); exp_t += 3;
        chk_time("R7 relocked new settings R9");

        wr(1'b0, 3'b011);
        wr(1'b1, 3'b000);
        wr(1'b1, 3'b001);
        ticks(6);
        chk_time("R6 captured hold stops");
        wr(1'b1, 3'b000);
        wr(1'b0, 3'b000);

        // full-day sweep, one tick per cycle
        @(negedge clk); tick = 1'b1;
        for (int i = 0; i < 86400; i++) begin
            @(negedge clk); exp_t++;
            chk_time("R8 sweep");
        end
        tick = 1'b0;
        @(negedge clk);
        chk_time("R8 wrap after day");

        wr(1'b1, 3'b001);
        @(negedge clk); bkp_por_n = 1'b0; sys_rst_n = 1'b0;
        repeat (2) @(negedge clk); bkp_por_n = 1'b1; sys_rst_n = 1'b1;
        @(negedge clk);
        exp_t = 0;
        rd(1'b1, v); chk("R4 lock cleared by por", v, 0);
        chk_time("R10 counters cleared by por");
        ticks(3);
        chk_time("R3 por leaves held");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule